// File: doc/BRIEF.md
# Fail-Safe Operating Mode Controller

This block is the operating-mode state machine of a supply and bus-interface companion chip that sits beside a microcontroller. It owns three operating states: Start-up, Normal and Sleep. From them it drives these outputs:

- the microcontroller reset line,
- the regulator enable,
- an active-high enable output,
- the inhibit/limp output-enable,
- the system-inhibit control,
- a 4-bit reset-source register.

Software can read the reset-source code after every restart and choose its start-up path from it.

Software changes mode by writing a 3-bit code through a write strobe. A simplified window-watchdog input says whether each write landed in a legal window. Flash programming is requested by a guarded sequence of three legal writes made while in Normal. The block answers that sequence with a restart tagged with its own reset-source code.

Sleep powers the microcontroller down. It is left through one of four causes, and each records its own code:

- a watchdog expiry, when the watchdog is still running,
- CAN bus activity,
- a synchronised falling edge on the wake pin,
- an auxiliary-supply overload, but only when that supply is switched on.

Top module: `failsafe_mode_ctrl`

## Requirements
- R1: While `rstN` is low and after its release, the controller is in Start-up (`curMode` = 2'b00) with `resetSrc` = 4'b0000. It holds `resetN` low for `RST_CYCLES` clock cycles after entering Start-up, with `regEnable` high and `enableOut` low. `curMode` encodes Normal as 2'b01 and Sleep as 2'b10.
- R2: A legal write (`modeWrStb` and `wdWindowOk` both high) of code 3'b101 in Start-up moves the controller to Normal on the next edge, but only once the reset pulse is over. The same code written during the pulse, or written outside the window, is ignored. In Normal, `resetN`, `regEnable`, `inhibitOe`, `sysInhibit` and `enableOut` are all high.
- R3: In Normal, three consecutive legal writes of 3'b111, 3'b001 and 3'b111 send the controller to Start-up with `resetSrc` = 4'b0110 and a new reset pulse.
- R4: In Normal, any write that does not match the next expected code clears the flash-entry progress back to the first step. Any write outside the window also clears it. A fresh complete sequence still succeeds after a clear.
- R5: A legal write of 3'b011 in Normal enters Sleep on the next edge. `resetN`, `regEnable` and `inhibitOe` are low from that cycle on.
- R6: In Sleep, `sysInhibit` follows `v2Ctrl`. In Start-up and Normal it is high.
- R7: `wdExpired` in Start-up or Normal restarts Start-up on the next edge with `resetSrc` = 4'b0010. `enableOut` is low from that cycle on.
- R8: In Sleep, `wdExpired` with `wdSleepRun` high moves the controller to Start-up with `resetSrc` = 4'b0011. With `wdSleepRun` low the expiry is ignored and Sleep holds.
- R9: In Sleep, `canWake` wakes the controller into Start-up with `resetSrc` = 4'b0100. A high-to-low change of `wakePin` is passed through a two-flop synchroniser and wakes with `resetSrc` = 4'b0101; the mode changes on the third rising edge after `wakePin` goes low.
- R10: In Sleep, `auxOverload` wakes with `resetSrc` = 4'b0111 only while `auxCyclicOrOn` is high. Otherwise it is ignored.
- R11: When wake causes coincide in Sleep, the priority is: watchdog expiry, then CAN, then wake pin, then overload. In Normal, a watchdog expiry wins over a completed flash sequence, and a completed flash sequence wins over a Sleep write.
- R12: `enableOut` is low in every cycle in which `resetN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| modeWrStb | input | 1 | Mode register write strobe |
| modeWrCode | input | 3 | Mode code carried by the write |
| wdWindowOk | input | 1 | High when the current write lies in a legal watchdog window |
| wdExpired | input | 1 | Watchdog period expiry / overflow pulse |
| wdSleepRun | input | 1 | Watchdog keeps running (time-out mode) during Sleep |
| canWake | input | 1 | CAN bus activity detected |
| wakePin | input | 1 | Asynchronous local wake input, falling edge wakes |
| auxOverload | input | 1 | Auxiliary supply overload flag |
| auxCyclicOrOn | input | 1 | Auxiliary supply is in cyclic or continuous-on mode |
| v2Ctrl | input | 1 | Keep the system-inhibit output active during Sleep |
| resetN | output | 1 | Microcontroller reset, active low |
| regEnable | output | 1 | Microcontroller regulator enable |
| enableOut | output | 1 | Active-high enable output |
| inhibitOe | output | 1 | Inhibit/limp output drive enable (low = high impedance) |
| sysInhibit | output | 1 | System-inhibit control |
| resetSrc | output | 4 | Reset-source code of the latest restart |
| curMode | output | 2 | Current operating mode |

## Verification
The assertions check several relations on every cycle:
- `enableOut` is never high while `resetN` is low.
- `sysInhibit` tracks `v2Ctrl` in Sleep.
- A legal Sleep write lands in Sleep with reset and regulator off.
- A watchdog expiry lands in Start-up with the right source code.
- A CAN wake and a running-watchdog expiry during Sleep leave with their codes.
- A code of 4'b0110 only appears right after Normal.

Other behaviours need the bench's scenarios, because they depend on history that a single-cycle property cannot see:
- the three-step flash sequence and the ways it is broken and restarted,
- the three-edge latency of the synchronised wake pin,
- overload being ignored while the auxiliary supply is off,
- the exact length of the reset pulse.

// File: rtl/fsmode_pkg.sv
package fsmode_pkg;

  typedef enum logic [1:0] {
    MODE_STARTUP = 2'b00,
    MODE_NORMAL  = 2'b01,
    MODE_SLEEP   = 2'b10
  } opMode_e;

  // mode register write codes
  localparam logic [2:0] WR_NORMAL  = 3'b101;
  localparam logic [2:0] WR_SLEEP   = 3'b011;
  localparam logic [2:0] WR_FLASH_A = 3'b111;
  localparam logic [2:0] WR_FLASH_B = 3'b001;
  localparam int         FLASH_STEPS = 3;

  // reset-source codes
  localparam logic [3:0] SRC_POWERON  = 4'b0000;
  localparam logic [3:0] SRC_WDOG     = 4'b0010;
  localparam logic [3:0] SRC_SLEEP_WD = 4'b0011;
  localparam logic [3:0] SRC_CAN      = 4'b0100;
  localparam logic [3:0] SRC_PIN      = 4'b0101;
  localparam logic [3:0] SRC_FLASH    = 4'b0110;
  localparam logic [3:0] SRC_OVERLOAD = 4'b0111;

  // control -> datapath strobes
  typedef struct packed {
    logic       loadReset;
    logic [3:0] srcCode;
  } ctrlStb_t;

  // datapath -> control status
  typedef struct packed {
    logic legalWr;
    logic cntZero;
    logic flashDone;
    logic pinFall;
  } dpStat_t;

  // expected code at each step of the flash-entry sequence
  function automatic logic [2:0] flashCode(input int step);
    return (step == 1) ? WR_FLASH_B : WR_FLASH_A;
  endfunction

endpackage

// File: rtl/mode_ctrl_datapath.sv
module mode_ctrl_datapath
  import fsmode_pkg::*;
#(
  parameter int RST_CYCLES  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrStb,
  input  logic [2:0] modeWrCode,
  input  logic       wdWindowOk,
  input  logic       wakePin,
  input  logic       inNormal,
  input  ctrlStb_t   stb,
  output dpStat_t    stat,
  output logic [3:0] resetSrc
);

  localparam int CNT_W  = $clog2(RST_CYCLES + 1);
  localparam int STEP_W = $clog2(FLASH_STEPS);

  // wake pin synchroniser and fall detector
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinLast;

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= wakePin;
      end
    end else begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], wakePin};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinLast <= 1'b1;
    else       pinLast <= syncQ[SYNC_STAGES-1];
  end

  // reset pulse counter
  logic [CNT_W-1:0] rstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rstCnt <= CNT_W'(RST_CYCLES);
    else if (stb.loadReset)  rstCnt <= CNT_W'(RST_CYCLES);
    else if (rstCnt != '0)   rstCnt <= rstCnt - 1'b1;
  end

  // flash-entry sequence tracker
  logic [STEP_W-1:0] step, stepNext;
  logic              legalWr, flashHit;

  assign legalWr = modeWrStb && wdWindowOk;

  always_comb begin
    stepNext = step;
    flashHit = 1'b0;
    if (!inNormal) begin
      stepNext = '0;
    end else if (modeWrStb) begin
      if (legalWr && modeWrCode == flashCode(int'(step))) begin
        if (int'(step) == FLASH_STEPS - 1) begin
          flashHit = 1'b1;
          stepNext = '0;
        end else begin
          stepNext = step + 1'b1;
        end
      end else begin
        stepNext = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) step <= '0;
    else       step <= stepNext;
  end

  // reset-source register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              resetSrc <= SRC_POWERON;
    else if (stb.loadReset) resetSrc <= stb.srcCode;
  end

  assign stat.legalWr   = legalWr;
  assign stat.cntZero   = (rstCnt == '0);
  assign stat.flashDone = flashHit;
  assign stat.pinFall   = pinLast && !syncQ[SYNC_STAGES-1];

endmodule

// File: rtl/mode_ctrl_fsm.sv
module mode_ctrl_fsm
  import fsmode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeWrCode,
  input  logic       wdExpired,
  input  logic       wdSleepRun,
  input  logic       canWake,
  input  logic       auxOverload,
  input  logic       auxCyclicOrOn,
  input  logic       v2Ctrl,
  input  dpStat_t    stat,
  output ctrlStb_t   stb,
  output logic       inNormal,
  output logic [1:0] curMode,
  output logic       resetN,
  output logic       regEnable,
  output logic       inhibitOe,
  output logic       sysInhibit,
  output logic       enableOut
);

  opMode_e mode, modeNext;

  always_comb begin
    modeNext      = mode;
    stb.loadReset = 1'b0;
    stb.srcCode   = SRC_POWERON;
    unique case (mode)
      MODE_STARTUP: begin
        if (wdExpired) begin
          stb.loadReset = 1'b1;
          stb.srcCode   = SRC_WDOG;
        end else if (stat.cntZero && stat.legalWr && modeWrCode == WR_NORMAL) begin
          modeNext = MODE_NORMAL;
        end
      end
      MODE_NORMAL: begin
        if (wdExpired) begin
          stb.loadReset = 1'b1;
          stb.srcCode   = SRC_WDOG;
        end else if (stat.flashDone) begin
          stb.loadReset = 1'b1;
          stb.srcCode   = SRC_FLASH;
        end else if (stat.legalWr && modeWrCode == WR_SLEEP) begin
          modeNext = MODE_SLEEP;
        end
      end
      MODE_SLEEP: begin
        if (wdExpired && wdSleepRun) begin
          stb.loadReset = 1'b1;
          stb.srcCode   = SRC_SLEEP_WD;
        end else if (canWake) begin
          stb.loadReset = 1'b1;
          stb.srcCode   = SRC_CAN;
        end else if (stat.pinFall) begin
          stb.loadReset = 1'b1;
          stb.srcCode   = SRC_PIN;
        end else if (auxOverload && auxCyclicOrOn) begin
          stb.loadReset = 1'b1;
          stb.srcCode   = SRC_OVERLOAD;
        end
      end
      default: begin
        stb.loadReset = 1'b1;
        stb.srcCode   = SRC_POWERON;
      end
    endcase
    if (stb.loadReset) modeNext = MODE_STARTUP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_STARTUP;
    else       mode <= modeNext;
  end

  assign inNormal   = (mode == MODE_NORMAL);
  assign curMode    = mode;
  assign resetN     = (mode == MODE_NORMAL) || (mode == MODE_STARTUP && stat.cntZero);
  assign regEnable  = (mode != MODE_SLEEP);
  assign inhibitOe  = (mode != MODE_SLEEP);
  assign sysInhibit = (mode != MODE_SLEEP) || v2Ctrl;
  assign enableOut  = (mode == MODE_NORMAL);

endmodule

// File: rtl/failsafe_mode_ctrl.sv
module failsafe_mode_ctrl
  import fsmode_pkg::*;
#(
  parameter int RST_CYCLES  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrStb,
  input  logic [2:0] modeWrCode,
  input  logic       wdWindowOk,
  input  logic       wdExpired,
  input  logic       wdSleepRun,
  input  logic       canWake,
  input  logic       wakePin,
  input  logic       auxOverload,
  input  logic       auxCyclicOrOn,
  input  logic       v2Ctrl,
  output logic       resetN,
  output logic       regEnable,
  output logic       enableOut,
  output logic       inhibitOe,
  output logic       sysInhibit,
  output logic [3:0] resetSrc,
  output logic [1:0] curMode
);

  ctrlStb_t stb;
  dpStat_t  stat;
  logic     inNormal;

  mode_ctrl_fsm uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .modeWrCode    (modeWrCode),
    .wdExpired     (wdExpired),
    .wdSleepRun    (wdSleepRun),
    .canWake       (canWake),
    .auxOverload   (auxOverload),
    .auxCyclicOrOn (auxCyclicOrOn),
    .v2Ctrl        (v2Ctrl),
    .stat          (stat),
    .stb           (stb),
    .inNormal      (inNormal),
    .curMode       (curMode),
    .resetN        (resetN),
    .regEnable     (regEnable),
    .inhibitOe     (inhibitOe),
    .sysInhibit    (sysInhibit),
    .enableOut     (enableOut)
  );

  mode_ctrl_datapath #(
    .RST_CYCLES  (RST_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrStb  (modeWrStb),
    .modeWrCode (modeWrCode),
    .wdWindowOk (wdWindowOk),
    .wakePin    (wakePin),
    .inNormal   (inNormal),
    .stb        (stb),
    .stat       (stat),
    .resetSrc   (resetSrc)
  );

endmodule

// File: rtl/mode_ctrl_checker.sv
module mode_ctrl_checker
  import fsmode_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       modeWrStb,
  input logic [2:0] modeWrCode,
  input logic       wdWindowOk,
  input logic       wdExpired,
  input logic       wdSleepRun,
  input logic       canWake,
  input logic       v2Ctrl,
  input logic       resetN,
  input logic       regEnable,
  input logic       inhibitOe,
  input logic       sysInhibit,
  input logic       enableOut,
  input logic [3:0] resetSrc,
  input logic [1:0] curMode
);

  assert_startup_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_STARTUP && !resetN && !wdExpired) |=> curMode == MODE_STARTUP);

  assert_flash_origin_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resetSrc == SRC_FLASH && !$stable(resetSrc)) |-> $past(curMode) == MODE_NORMAL);

  assert_sleep_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_NORMAL && modeWrStb && wdWindowOk && modeWrCode == WR_SLEEP && !wdExpired)
    |=> (curMode == MODE_SLEEP && !resetN && !regEnable && !inhibitOe));

  assert_sleep_sysinh_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_SLEEP) |-> sysInhibit == v2Ctrl);

  assert_wd_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != MODE_SLEEP && wdExpired)
    |=> (curMode == MODE_STARTUP && !enableOut && !resetN && resetSrc == SRC_WDOG));

  assert_sleep_wd_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_SLEEP && wdExpired && wdSleepRun)
    |=> (curMode == MODE_STARTUP && resetSrc == SRC_SLEEP_WD));

  assert_can_wake_R9: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_SLEEP && canWake && !(wdExpired && wdSleepRun))
    |=> (curMode == MODE_STARTUP && resetSrc == SRC_CAN));

  assert_enable_reset_R12: assert property (@(posedge clk) disable iff (!rstN)
    !resetN |-> !enableOut);

endmodule

bind failsafe_mode_ctrl mode_ctrl_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .modeWrStb  (modeWrStb),
  .modeWrCode (modeWrCode),
  .wdWindowOk (wdWindowOk),
  .wdExpired  (wdExpired),
  .wdSleepRun (wdSleepRun),
  .canWake    (canWake),
  .v2Ctrl     (v2Ctrl),
  .resetN     (resetN),
  .regEnable  (regEnable),
  .inhibitOe  (inhibitOe),
  .sysInhibit (sysInhibit),
  .enableOut  (enableOut),
  .resetSrc   (resetSrc),
  .curMode    (curMode)
);

// File: tb/failsafe_mode_ctrl_test.sv
`timescale 1ns/100ps
module failsafe_mode_ctrl_test;

  localparam int RST_CYC = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN, modeWrStb, wdWindowOk, wdExpired, wdSleepRun;
  logic       canWake, wakePin, auxOverload, auxCyclicOrOn, v2Ctrl;
  logic [2:0] modeWrCode;
  logic       resetN, regEnable, enableOut, inhibitOe, sysInhibit;
  logic [3:0] resetSrc;
  logic [1:0] curMode;

  failsafe_mode_ctrl #(.RST_CYCLES(RST_CYC), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .modeWrStb(modeWrStb), .modeWrCode(modeWrCode),
    .wdWindowOk(wdWindowOk), .wdExpired(wdExpired), .wdSleepRun(wdSleepRun),
    .canWake(canWake), .wakePin(wakePin), .auxOverload(auxOverload),
    .auxCyclicOrOn(auxCyclicOrOn), .v2Ctrl(v2Ctrl), .resetN(resetN),
    .regEnable(regEnable), .enableOut(enableOut), .inhibitOe(inhibitOe),
    .sysInhibit(sysInhibit), .resetSrc(resetSrc), .curMode(curMode)
  );

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model: 0 startup, 1 normal, 2 sleep
  int mMode, mCnt, mSrc, mStep;
  int hist[$];
  bit legal, pinFell, fdone, ld;
  int srcNew;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mCnt = RST_CYC; mSrc = 0; mStep = 0;
      hist = '{1, 1, 1};
    end else begin
      legal   = modeWrStb && wdWindowOk;
      pinFell = (hist[0] == 1) && (hist[1] == 0);
      hist.push_back(int'(wakePin));
      void'(hist.pop_front());
      fdone = 0; ld = 0; srcNew = 0;
      if (mMode == 1 && !wdExpired) begin
        if (modeWrStb) begin
          if (legal && modeWrCode == ((mStep == 1) ? 3'b001 : 3'b111)) begin
            if (mStep == 2) begin fdone = 1; mStep = 0; end
            else mStep++;
          end else mStep = 0;
        end
      end else mStep = 0;
      case (mMode)
        0: if (wdExpired) begin ld = 1; srcNew = 2; end
           else if (mCnt == 0 && legal && modeWrCode == 3'b101) mMode = 1;
        1: if (wdExpired) begin ld = 1; srcNew = 2; end
           else if (fdone) begin ld = 1; srcNew = 6; end
           else if (legal && modeWrCode == 3'b011) mMode = 2;
        default: if (wdExpired && wdSleepRun) begin ld = 1; srcNew = 3; end
           else if (canWake) begin ld = 1; srcNew = 4; end
           else if (pinFell) begin ld = 1; srcNew = 5; end
           else if (auxOverload && auxCyclicOrOn) begin ld = 1; srcNew = 7; end
      endcase
      if (ld) begin mMode = 0; mCnt = RST_CYC; mSrc = srcNew; end
      else if (mCnt > 0) mCnt--;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    automatic int eRst  = (mMode == 1 || (mMode == 0 && mCnt == 0)) ? 1 : 0;
    automatic int eReg  = (mMode != 2) ? 1 : 0;
    automatic int eSys  = (mMode != 2 || v2Ctrl) ? 1 : 0;
    automatic int eEn   = (mMode == 1) ? 1 : 0;
    automatic int expV  = (mMode << 10) | (eRst << 9) | (eReg << 8) | (eReg << 7)
                        | (eSys << 6) | (eEn << 5) | mSrc;
    automatic int actV  = (int'(curMode) << 10) | (int'(resetN) << 9) | (int'(regEnable) << 8)
                        | (int'(inhibitOe) << 7) | (int'(sysInhibit) << 6)
                        | (int'(enableOut) << 5) | int'(resetSrc);
    checkEq(curReq, "model", actV, expV);
    checkEq("R12", "enable while reset", int'(!resetN && enableOut), 0);
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] code, input logic ok);
    modeWrStb = 1'b1; modeWrCode = code; wdWindowOk = ok;
    step();
    modeWrStb = 1'b0; wdWindowOk = 1'b0;
  endtask

  task automatic goNormal();
    repeat (RST_CYC + 2) step();
    wr(3'b101, 1'b1);
  endtask

  task automatic goSleep();
    goNormal();
    wr(3'b011, 1'b1);
  endtask

  initial begin
    rstN = 1'b0; modeWrStb = 1'b0; modeWrCode = 3'b000; wdWindowOk = 1'b0;
    wdExpired = 1'b0; wdSleepRun = 1'b0; canWake = 1'b0; wakePin = 1'b1;
    auxOverload = 1'b0; auxCyclicOrOn = 1'b0; v2Ctrl = 1'b0;
    repeat (3) step();
    // R1 reset state
    checkEq("R1", "mode in reset", curMode, 0);
    checkEq("R1", "src in reset", resetSrc, 0);
    checkEq("R1", "resetN in reset", resetN, 0);
    checkEq("R1", "regEnable in reset", regEnable, 1);
    checkEq("R1", "enableOut in reset", enableOut, 0);
    rstN = 1'b1;

    curReq = "R2";
    wr(3'b101, 1'b1);
    checkEq("R2", "write during pulse ignored", curMode, 0);
    repeat (RST_CYC + 2) step();
    checkEq("R1", "pulse over", resetN, 1);
    wr(3'b101, 1'b0);
    checkEq("R2", "out-of-window write ignored", curMode, 0);
    wr(3'b101, 1'b1);
    checkEq("R2", "normal entered", curMode, 1);
    checkEq("R2", "normal enable", enableOut, 1);
    checkEq("R6", "normal sysInhibit", sysInhibit, 1);

    curReq = "R3";
    wr(3'b111, 1'b1);
    wr(3'b001, 1'b1);
    checkEq("R3", "two steps stay normal", curMode, 1);
    wr(3'b111, 1'b1);
    checkEq("R3", "flash to startup", curMode, 0);
    checkEq("R3", "flash source", resetSrc, 6);
    checkEq("R3", "flash reset", resetN, 0);

    curReq = "R4";
    goNormal();
    wr(3'b111, 1'b1); wr(3'b101, 1'b1); wr(3'b001, 1'b1); wr(3'b111, 1'b1);
    checkEq("R4", "broken sequence", curMode, 1);
    wr(3'b001, 1'b0); wr(3'b111, 1'b1); wr(3'b001, 1'b1);
    checkEq("R4", "window break then restart", curMode, 1);
    step();
    wr(3'b111, 1'b1);
    checkEq("R4", "restarted sequence completes", resetSrc, 6);

    curReq = "R5";
    v2Ctrl = 1'b0;
    goSleep();
    checkEq("R5", "sleep mode", curMode, 2);
    checkEq("R5", "sleep reset", resetN, 0);
    checkEq("R5", "sleep regulator", regEnable, 0);
    checkEq("R5", "sleep inhibit", inhibitOe, 0);
    checkEq("R6", "sysInhibit v2 low", sysInhibit, 0);
    curReq = "R6";
    v2Ctrl = 1'b1;
    step();
    checkEq("R6", "sysInhibit v2 high", sysInhibit, 1);

    curReq = "R8";
    wdExpired = 1'b1; wdSleepRun = 1'b0;
    step();
    wdExpired = 1'b0;
    checkEq("R8", "stopped watchdog ignored", curMode, 2);
    wdExpired = 1'b1; wdSleepRun = 1'b1;
    step();
    wdExpired = 1'b0; wdSleepRun = 1'b0;
    checkEq("R8", "cyclic wake", curMode, 0);
    checkEq("R8", "cyclic source", resetSrc, 3);

    curReq = "R9";
    goSleep();
    canWake = 1'b1;
    step();
    canWake = 1'b0;
    checkEq("R9", "can wake source", resetSrc, 4);
    goSleep();
    wakePin = 1'b0;
    step();
    checkEq("R9", "pin edge 1", curMode, 2);
    step();
    checkEq("R9", "pin edge 2", curMode, 2);
    step();
    checkEq("R9", "pin edge 3 wakes", curMode, 0);
    checkEq("R9", "pin source", resetSrc, 5);
    wakePin = 1'b1;

    curReq = "R10";
    goSleep();
    auxOverload = 1'b1; auxCyclicOrOn = 1'b0;
    step();
    checkEq("R10", "overload with supply off", curMode, 2);
    auxCyclicOrOn = 1'b1;
    step();
    auxOverload = 1'b0; auxCyclicOrOn = 1'b0;
    checkEq("R10", "overload source", resetSrc, 7);

    curReq = "R11";
    goSleep();
    canWake = 1'b1; auxOverload = 1'b1; auxCyclicOrOn = 1'b1;
    wdExpired = 1'b1; wdSleepRun = 1'b1;
    step();
    canWake = 1'b0; auxOverload = 1'b0; auxCyclicOrOn = 1'b0;
    wdExpired = 1'b0; wdSleepRun = 1'b0;
    checkEq("R11", "watchdog wins in sleep", resetSrc, 3);
    goSleep();
    canWake = 1'b1; auxOverload = 1'b1; auxCyclicOrOn = 1'b1;
    step();
    canWake = 1'b0; auxOverload = 1'b0; auxCyclicOrOn = 1'b0;
    checkEq("R11", "can wins over overload", resetSrc, 4);

    curReq = "R7";
    goNormal();
    wdExpired = 1'b1;
    step();
    wdExpired = 1'b0;
    checkEq("R7", "watchdog restart mode", curMode, 0);
    checkEq("R7", "watchdog source", resetSrc, 2);
    checkEq("R7", "enable dropped", enableOut, 0);

    curReq = "R11";
    goNormal();
    wdExpired = 1'b1;
    wr(3'b011, 1'b1);
    wdExpired = 1'b0;
    checkEq("R11", "watchdog wins over sleep write", curMode, 0);
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule